// File: doc/BRIEF.md
# Parallel Converter Bus Sequencer

This block sits on the host side of a 12-bit parallel digital-to-analog converter that has an input latch and a second output latch. It takes one request at a time from a valid/ready command port. The request can be a write, a read-back, a load, a reset, or a write followed by a load. For each request it produces the chip-select, read/write, load and reset strobes, and it drives or releases the shared data bus. Every timing minimum is given in nanoseconds as a parameter. Each one is turned into whole clock cycles by rounding up, and it is never less than one cycle.

A write holds the bus and the write level of read/write for the whole select pulse and for a hold window after it. A read first releases the bus and raises read/write for a setup window. It then holds select low for the longer of the minimum read pulse and the data-valid time. It samples the bus in the last low cycle and returns the word with a one-cycle response pulse. After a read, the bus is not driven again until the release time has passed. The load and reset strobes have their own minimum widths. The reset request also sets a select line that chooses a mid-scale or a zero-scale reset code.

The control path is one state machine with these states: IDLE, WR_WAIT, WR_CS, WR_HOLD, RD_SETUP, RD_CS, LOAD and RESET. The transitions are:
- IDLE goes to WR_CS, or to WR_WAIT while the release window runs, on a write or write+load request.
- IDLE goes to RD_SETUP on a read, to LOAD on a load and to RESET on a reset.
- WR_WAIT goes to WR_CS when the release window ends.
- WR_CS goes to WR_HOLD, and WR_HOLD goes to LOAD for write+load or to IDLE otherwise.
- RD_SETUP goes to RD_CS, and RD_CS goes to IDLE.
- LOAD and RESET return to IDLE when their width has elapsed.

Each timed state leaves when its cycle count ends.

Top module: `dacbus_sequencer`

## Requirements
- R1: During and right after reset, the outputs are: dac_cs_n=1, dac_rw=1, dac_load_n=1, dac_rst_n=1, dac_bus_oe=0, cmd_ready=1 and rsp_valid=0.
- R2: A write (cmd_op=0) holds dac_cs_n low for exactly ceil(T_WR_CS_NS/CLK_NS) cycles. Through that pulse, dac_rw=0 (0 means write) and dac_bus_oe=1, and dac_bus_out carries the command data.
- R3: After the write select rises, dac_rw stays 0 and the bus stays driven with the same data for at least ceil(T_WR_HOLD_NS/CLK_NS) cycles.
- R4: A read (cmd_op=1) keeps dac_rw=1 with the bus released for at least ceil(T_RD_SETUP_NS/CLK_NS) cycles before select falls. It then holds select low for exactly max(ceil(T_RD_CS_NS/CLK_NS), ceil(T_RD_VALID_NS/CLK_NS)) cycles with the bus released.
- R5: rsp_valid is high for exactly one cycle per read, in the cycle in which the read select rises. rsp_data is the dac_bus_in value of the last select-low cycle.
- R6: After a read select rises, dac_bus_oe stays 0 for at least ceil(T_RELEASE_NS/CLK_NS) cycles.
- R7: A load (cmd_op=2) gives one dac_load_n low pulse of exactly ceil(T_LOAD_NS/CLK_NS) cycles.
- R8: A reset (cmd_op=3) gives one dac_rst_n low pulse of exactly ceil(T_RESET_NS/CLK_NS) cycles. dac_mid_sel equals cmd_mid (1 means mid-scale, 0 means zero-scale) at the start of the pulse and holds through it.
- R9: A write+load (cmd_op=4) runs a full write, including its hold, and then one load pulse. cmd_ready stays 0 until that load pulse has ended.
- R10: Each time minimum is rounded up to whole cycles with a floor of one cycle. With CLK_NS=10, a 5 ns hold becomes 1 cycle.
- R11: cmd_ready is 1 only when no strobe is low and the bus is not driven. At most one of the three strobes is low at any time. Codes 5 to 7 are accepted and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Sequencer idle, request taken on this edge when valid |
| cmd_op | input | 3 | 0 write, 1 read, 2 load, 3 reset, 4 write+load, 5-7 no action |
| cmd_data | input | W | Word to write |
| cmd_mid | input | 1 | Reset code choice: 1 mid-scale, 0 zero-scale |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_data | output | W | Word read back |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_rw | output | 1 | 1 read, 0 write |
| dac_load_n | output | 1 | Output-latch load strobe, active low |
| dac_rst_n | output | 1 | Converter reset strobe, active low |
| dac_mid_sel | output | 1 | Reset code select, 1 mid-scale |
| dac_bus_out | output | W | Data driven to the bus |
| dac_bus_oe | output | 1 | Bus driver enable |
| dac_bus_in | input | W | Data seen on the bus |

## Verification
All strobe outputs are registered from the next state. A strobe therefore moves on the edge that accepts a request, or on the edge that ends the previous timed state. With default parameters:
- A write select falls on the accept edge and rises 5 cycles later.
- A read select falls one setup cycle after the accept edge and rises 20 cycles after that.
- rsp_valid rises on that same rising edge.

The bench samples every output on the falling clock edge. It counts run lengths of each strobe and compares them at the first high sample. It compares the response in the very sample where the read select is first seen high. It measures hold and release windows in cycles from that rise. A converter model drives valid read data only from the valid-time cycle onward and drives the inverted word at all other times. A capture in the wrong cycle is therefore visible in the data.

// File: rtl/dacbus_pkg.sv
package dacbus_pkg;

    typedef enum logic [2:0] {
        OP_WRITE  = 3'd0,
        OP_READ   = 3'd1,
        OP_LOAD   = 3'd2,
        OP_RESET  = 3'd3,
        OP_WRLOAD = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_WAIT,
        ST_WR_CS,
        ST_WR_HOLD,
        ST_RD_SETUP,
        ST_RD_CS,
        ST_LOAD,
        ST_RESET
    } state_e;

    // R10: nanoseconds to cycles, rounded up, never below one cycle
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacbus_timer.sv
// Counts cycles spent in the current state; restarts whenever the state changes.
module dacbus_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] target,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (cnt != {CW{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == target - 1'b1);
endmodule

// File: rtl/dacbus_guard.sv
// Bus-release window after a read: clear only once RELC cycles have gone by.
module dacbus_guard #(
    parameter int CW   = 6,
    parameter int RELC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic clear
);
    logic [CW-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left <= '0;
        end else if (arm) begin
            left <= CW'(RELC);
        end else if (left != '0) begin
            left <= left - 1'b1;
        end
    end

    assign clear = (left == '0);
endmodule

// File: rtl/dacbus_capture.sv
// Samples the bus on the edge that ends the read strobe and pulses valid for one cycle.
module dacbus_capture #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic [W-1:0] din,
    output logic         valid,
    output logic [W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= take;
            if (take) begin
                data <= din;
            end
        end
    end
endmodule

// File: rtl/dacbus_sequencer.sv
module dacbus_sequencer
    import dacbus_pkg::*;
#(
    parameter int W               = 12,
    parameter int CLK_NS          = 10,
    parameter int T_WR_CS_NS      = 50,
    parameter int T_WR_HOLD_NS    = 5,
    parameter int T_RD_SETUP_NS   = 10,
    parameter int T_RD_CS_NS      = 200,
    parameter int T_RD_VALID_NS   = 160,
    parameter int T_RELEASE_NS    = 100,
    parameter int T_LOAD_NS       = 50,
    parameter int T_RESET_NS      = 50
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    output logic         cmd_ready,
    input  logic [2:0]   cmd_op,
    input  logic [W-1:0] cmd_data,
    input  logic         cmd_mid,
    output logic         rsp_valid,
    output logic [W-1:0] rsp_data,
    output logic         dac_cs_n,
    output logic         dac_rw,
    output logic         dac_load_n,
    output logic         dac_rst_n,
    output logic         dac_mid_sel,
    output logic [W-1:0] dac_bus_out,
    output logic         dac_bus_oe,
    input  logic [W-1:0] dac_bus_in
);
    localparam int C_WR_CS   = ns2cyc(T_WR_CS_NS, CLK_NS);
    localparam int C_WR_HOLD = ns2cyc(T_WR_HOLD_NS, CLK_NS);
    localparam int C_RD_SU   = ns2cyc(T_RD_SETUP_NS, CLK_NS);
    localparam int C_RD_CS   = umax(ns2cyc(T_RD_CS_NS, CLK_NS), ns2cyc(T_RD_VALID_NS, CLK_NS));
    localparam int C_REL     = ns2cyc(T_RELEASE_NS, CLK_NS);
    localparam int C_LOAD    = ns2cyc(T_LOAD_NS, CLK_NS);
    localparam int C_RST     = ns2cyc(T_RESET_NS, CLK_NS);
    localparam int C_MAX     = umax(umax(umax(C_WR_CS, C_WR_HOLD), umax(C_RD_SU, C_RD_CS)),
                                    umax(umax(C_REL, C_LOAD), C_RST));
    localparam int CW        = $clog2(C_MAX + 1) + 1;

    state_e        state, nxt;
    logic [2:0]    op_q;
    logic          accept;
    logic          last;
    logic          clear;
    logic          take;
    logic [CW-1:0] target;

    assign cmd_ready = (state == ST_IDLE);
    assign accept    = cmd_ready && cmd_valid;
    assign take      = (state == ST_RD_CS) && last;

    // per-state duration
    always_comb begin
        unique case (state)
            ST_WR_CS:    target = CW'(C_WR_CS);
            ST_WR_HOLD:  target = CW'(C_WR_HOLD);
            ST_RD_SETUP: target = CW'(C_RD_SU);
            ST_RD_CS:    target = CW'(C_RD_CS);
            ST_LOAD:     target = CW'(C_LOAD);
            ST_RESET:    target = CW'(C_RST);
            default:     target = CW'(1);
        endcase
    end

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (cmd_op)
                        OP_WRITE, OP_WRLOAD: nxt = clear ? ST_WR_CS : ST_WR_WAIT;
                        OP_READ:             nxt = ST_RD_SETUP;
                        OP_LOAD:             nxt = ST_LOAD;
                        OP_RESET:            nxt = ST_RESET;
                        default:             nxt = ST_IDLE;
                    endcase
                end
            end
            ST_WR_WAIT:  if (clear) nxt = ST_WR_CS;
            ST_WR_CS:    if (last)  nxt = ST_WR_HOLD;
            ST_WR_HOLD:  if (last)  nxt = (op_q == OP_WRLOAD) ? ST_LOAD : ST_IDLE;
            ST_RD_SETUP: if (last)  nxt = ST_RD_CS;
            ST_RD_CS:    if (last)  nxt = ST_IDLE;
            ST_LOAD:     if (last)  nxt = ST_IDLE;
            ST_RESET:    if (last)  nxt = ST_IDLE;
            default:                nxt = ST_IDLE;
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op_q  <= 3'd0;
        end else begin
            state <= nxt;
            if (accept) begin
                op_q <= cmd_op;
            end
        end
    end

    // registered pin outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_cs_n    <= 1'b1;
            dac_rw      <= 1'b1;
            dac_bus_oe  <= 1'b0;
            dac_load_n  <= 1'b1;
            dac_rst_n   <= 1'b1;
            dac_mid_sel <= 1'b0;
            dac_bus_out <= '0;
        end else begin
            dac_cs_n   <= !((nxt == ST_WR_CS) || (nxt == ST_RD_CS));
            dac_rw     <= !((nxt == ST_WR_CS) || (nxt == ST_WR_HOLD));
            dac_bus_oe <= (nxt == ST_WR_CS) || (nxt == ST_WR_HOLD);
            dac_load_n <= (nxt != ST_LOAD);
            dac_rst_n  <= (nxt != ST_RESET);
            if (accept && (cmd_op == OP_RESET)) begin
                dac_mid_sel <= cmd_mid;
            end
            if (accept && ((cmd_op == OP_WRITE) || (cmd_op == OP_WRLOAD))) begin
                dac_bus_out <= cmd_data;
            end
        end
    end

    dacbus_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (nxt != state),
        .target  (target),
        .last    (last)
    );

    dacbus_guard #(.CW(CW), .RELC(C_REL)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (take),
        .clear (clear)
    );

    dacbus_capture #(.W(W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .din   (dac_bus_in),
        .valid (rsp_valid),
        .data  (rsp_data)
    );
endmodule

// File: rtl/dacbus_sequencer_chk.sv
module dacbus_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_ready,
    input logic rsp_valid,
    input logic dac_cs_n,
    input logic dac_rw,
    input logic dac_load_n,
    input logic dac_rst_n,
    input logic dac_mid_sel,
    input logic dac_bus_oe
);
    // R2: a write select is always accompanied by a driven bus
    a_r2_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && !dac_rw) |-> dac_bus_oe);

    // R4: a read select never sees the bus driven
    a_r4_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && dac_rw) |-> !dac_bus_oe);

    // R3: write level and drive survive the select rising edge
    a_r3_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_cs_n && !$past(dac_cs_n) && !$past(dac_rw)) |-> (!dac_rw && dac_bus_oe));

    // R5: response appears exactly as a read select ends and lasts one cycle
    a_r5_rsp_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (dac_cs_n && !$past(dac_cs_n) && $past(dac_rw)));
    a_r5_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8: reset-code choice is steady while the reset strobe is low
    a_r8_sel_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_rst_n && !$past(dac_rst_n)) |-> $stable(dac_mid_sel));

    // R11: strobes exclusive, ready only when quiet
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!dac_cs_n, !dac_load_n, !dac_rst_n}) <= 1);
    a_r11_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (dac_cs_n && dac_load_n && dac_rst_n && !dac_bus_oe));
endmodule

bind dacbus_sequencer dacbus_sequencer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_ready   (cmd_ready),
    .rsp_valid   (rsp_valid),
    .dac_cs_n    (dac_cs_n),
    .dac_rw      (dac_rw),
    .dac_load_n  (dac_load_n),
    .dac_rst_n   (dac_rst_n),
    .dac_mid_sel (dac_mid_sel),
    .dac_bus_oe  (dac_bus_oe)
);

// File: tb/sim_dacbus_sequencer.sv
`timescale 1ns/1ps
module sim_dacbus_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 12;
    localparam int WD_LIMIT   = 150000;

    function automatic int cyc_of(input int ns);
        int c;
        c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int C_WRCS = cyc_of(50);
    localparam int C_WRH  = cyc_of(5);
    localparam int C_RDSU = cyc_of(10);
    localparam int C_RDV  = cyc_of(160);
    localparam int C_RDCS = (cyc_of(200) > C_RDV) ? cyc_of(200) : C_RDV;
    localparam int C_REL  = cyc_of(100);
    localparam int C_LD   = cyc_of(50);
    localparam int C_RS   = cyc_of(50);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [2:0]   cmd_op = 3'd0;
    logic [W-1:0] cmd_data = '0;
    logic         cmd_mid = 1'b0;
    logic         rsp_valid;
    logic [W-1:0] rsp_data;
    logic         dac_cs_n, dac_rw, dac_load_n, dac_rst_n, dac_mid_sel, dac_bus_oe;
    logic [W-1:0] dac_bus_out;
    logic [W-1:0] dac_bus_in = '0;

    dacbus_sequencer #(.W(W), .CLK_NS(CLK_PERIOD)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_mid(cmd_mid),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .dac_cs_n(dac_cs_n), .dac_rw(dac_rw), .dac_load_n(dac_load_n),
        .dac_rst_n(dac_rst_n), .dac_mid_sel(dac_mid_sel),
        .dac_bus_out(dac_bus_out), .dac_bus_oe(dac_bus_oe), .dac_bus_in(dac_bus_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT && !done) begin
            check(1'b0, "R11 watchdog expired", cyc, WD_LIMIT);
            summary();
            $finish;
        end
    end

    // expected values, set by the stimulus
    logic [W-1:0] exp_wd = '0;
    logic [W-1:0] exp_rd = '0;
    bit           exp_sel = 0;
    bit           wl_mode = 0;
    int exp_cs = 0, exp_ld = 0, exp_rs = 0, exp_rsp = 0;

    // converter model: read data valid only from the valid-time cycle on
    int lowc = 0;
    always @(negedge clk) begin
        if (!dac_cs_n && dac_rw) lowc++;
        else lowc = 0;
        dac_bus_in = (lowc >= C_RDV + 1) ? exp_rd : ~exp_rd;
    end

    // pin monitor
    bit prev_cs = 1, prev_ld = 1, prev_rs = 1;
    bit cur_rd = 0, in_hold = 0, rel_watch = 0, wr_done = 0;
    int cs_run = 0, ld_run = 0, rs_run = 0, pre_rd = 0, hold_cnt = 0, since_rd = 0;
    int n_cs = 0, n_ld = 0, n_rs = 0, n_rsp = 0;
    bit bad_cs_body = 0, bad_rsp = 0, bad_ready = 0, bad_overlap = 0, bad_sel = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!dac_cs_n) begin
                if (prev_cs) begin
                    n_cs++;
                    cur_rd = dac_rw;
                    cs_run = 0;
                    if (dac_rw) check(pre_rd >= C_RDSU, "R4 read setup cycles", pre_rd, C_RDSU);
                    else check(dac_bus_oe && dac_bus_out == exp_wd, "R2 write data at select fall",
                               int'(dac_bus_out), int'(exp_wd));
                end
                cs_run++;
                pre_rd = 0;
                if (dac_rw != cur_rd) bad_cs_body = 1;
                if (!cur_rd && (!dac_bus_oe || dac_bus_out != exp_wd)) bad_cs_body = 1;
                if (cur_rd && dac_bus_oe) bad_cs_body = 1;
            end else begin
                if (!prev_cs) begin
                    if (cur_rd) begin
                        check(cs_run == C_RDCS, "R4 read select width", cs_run, C_RDCS);
                        check(rsp_valid && rsp_data == exp_rd, "R5 read word at select rise",
                              int'(rsp_data), int'(exp_rd));
                        rel_watch = 1;
                        since_rd = 0;
                    end else begin
                        check(cs_run == C_WRCS, "R2 write select width", cs_run, C_WRCS);
                        in_hold = 1;
                        hold_cnt = 0;
                        wr_done = 1;
                    end
                end else begin
                    since_rd++;
                end
                if (dac_rw && !dac_bus_oe) pre_rd++;
                else pre_rd = 0;
            end
            if (in_hold) begin
                if (dac_cs_n && !dac_rw && dac_bus_oe && dac_bus_out == exp_wd) hold_cnt++;
                else begin
                    check(hold_cnt >= C_WRH, "R3 R10 write hold cycles", hold_cnt, C_WRH);
                    in_hold = 0;
                end
            end
            if (rel_watch && dac_bus_oe) begin
                check(since_rd >= C_REL, "R6 release before drive", since_rd, C_REL);
                rel_watch = 0;
            end
            if (rsp_valid) begin
                n_rsp++;
                if (!(dac_cs_n && !prev_cs && cur_rd)) bad_rsp = 1;
            end
            if (!dac_load_n) begin
                if (prev_ld) begin
                    n_ld++;
                    ld_run = 0;
                    if (wl_mode) check(wr_done && !in_hold, "R9 load follows finished write",
                                       int'(wr_done), 1);
                end
                ld_run++;
            end else if (!prev_ld) begin
                check(ld_run == C_LD, "R7 load width", ld_run, C_LD);
            end
            if (!dac_rst_n) begin
                if (prev_rs) begin
                    n_rs++;
                    rs_run = 0;
                    check(dac_mid_sel == exp_sel, "R8 reset code select", int'(dac_mid_sel), int'(exp_sel));
                end
                rs_run++;
                if (dac_mid_sel != exp_sel) bad_sel = 1;
            end else if (!prev_rs) begin
                check(rs_run == C_RS, "R8 reset width", rs_run, C_RS);
            end
            if (cmd_ready && (!dac_cs_n || !dac_load_n || !dac_rst_n || dac_bus_oe)) bad_ready = 1;
            if ($countones({~dac_cs_n, ~dac_load_n, ~dac_rst_n}) > 1) bad_overlap = 1;
            prev_cs = dac_cs_n;
            prev_ld = dac_load_n;
            prev_rs = dac_rst_n;
        end
    end

    task automatic send(input logic [2:0] op, input logic [W-1:0] d, input logic s);
        int ld_before;
        @(negedge clk);
        cmd_op   = op;
        cmd_data = d;
        cmd_mid  = s;
        wl_mode  = (op == 3'd4);
        wr_done  = 0;
        ld_before = n_ld;
        if (op == 3'd0 || op == 3'd4) begin exp_wd = d; exp_cs++; end
        if (op == 3'd1) begin exp_rd = d; exp_cs++; exp_rsp++; end
        if (op == 3'd2 || op == 3'd4) exp_ld++;
        if (op == 3'd3) begin exp_sel = s; exp_rs++; end
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
        if (op == 3'd4) check(n_ld == ld_before + 1, "R9 ready held until load ends", n_ld - ld_before, 1);
    endtask

    initial begin
        int unsigned seed;
        int          n_before;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        check(dac_cs_n && dac_rw && dac_load_n && dac_rst_n && !dac_bus_oe && cmd_ready && !rsp_valid,
              "R1 outputs in reset", int'({dac_cs_n, dac_rw, dac_load_n, dac_rst_n, dac_bus_oe}), 5'b11110);
        rst_n = 1'b1;
        @(negedge clk);
        check(dac_cs_n && dac_rw && dac_load_n && dac_rst_n && !dac_bus_oe && cmd_ready && !rsp_valid,
              "R1 outputs after reset", int'({dac_cs_n, dac_rw, dac_load_n, dac_rst_n, dac_bus_oe}), 5'b11110);

        // directed corners
        send(3'd0, 12'hFFF, 1'b0);          // R2 R3 full-scale write
        send(3'd0, 12'h000, 1'b0);          // R2 zero write
        send(3'd1, 12'hA5C, 1'b0);          // R4 R5 read
        send(3'd0, 12'h3C3, 1'b0);          // R6 write right after read
        send(3'd4, 12'h800, 1'b0);          // R9 write+load
        send(3'd1, 12'h001, 1'b0);          // R5 read then R9 write+load in release window
        send(3'd4, 12'h7FE, 1'b0);
        send(3'd2, 12'h000, 1'b0);          // R7 load
        send(3'd3, 12'h000, 1'b1);          // R8 mid-scale
        send(3'd3, 12'h000, 1'b0);          // R8 zero-scale
        // R11: unused code produces nothing
        n_before = n_cs + n_ld + n_rs;
        send(3'd6, 12'h123, 1'b1);
        repeat (8) @(negedge clk);
        check(n_cs + n_ld + n_rs == n_before, "R11 unused code no strobe", n_cs + n_ld + n_rs, n_before);

        // random mix
        for (int i = 0; i < 80; i++) begin
            send(3'($urandom_range(0, 7)), W'($urandom), 1'($urandom));
        end
        repeat (30) @(negedge clk);

        check(n_cs == exp_cs, "R2 R4 select pulse count", n_cs, exp_cs);
        check(n_ld == exp_ld, "R7 load pulse count", n_ld, exp_ld);
        check(n_rs == exp_rs, "R8 reset pulse count", n_rs, exp_rs);
        check(n_rsp == exp_rsp, "R5 response count", n_rsp, exp_rsp);
        check(!bad_cs_body, "R2 R4 select body levels", int'(bad_cs_body), 0);
        check(!bad_rsp, "R5 response timing", int'(bad_rsp), 0);
        check(!bad_sel, "R8 select held", int'(bad_sel), 0);
        check(!bad_ready, "R11 ready only when quiet", int'(bad_ready), 0);
        check(!bad_overlap, "R11 strobe exclusivity", int'(bad_overlap), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule